// File: doc/BRIEF.md
# Eight-Stage Pipeline Interlock Controller

This block decides, cycle by cycle, whether the front of a superpipelined integer core may advance. The core has eight stages: two fetch halves (IF, IS), decode and register read (RF), execute (EX), two data-cache halves (DF, DS), tag check (TC) and writeback (WB). Each fetched instruction enters the controller as a descriptor. The descriptor names the destination register, up to two source registers with enable bits, a load flag, a branch flag and the branch outcome. The controller carries these descriptors through shadow copies of all eight stages.

A load's value becomes usable only once the load has left DS. If an instruction in RF reads the destination of a load that is still in EX or DF, the controller freezes IF, IS and RF and sends an empty slot into EX instead. The stall lasts two cycles when the consumer follows the load directly, one cycle when it is two slots behind, and no cycles when it is further behind. Branches resolve in EX. The instruction after a branch always executes. The two behind that one are fetched as if the branch falls through. When the branch in EX turns out taken, those two are turned into empty slots and fetch is told to redirect.

Top module: `ilk_pipe_interlock`

## Requirements
- R1: After a synchronous active-low reset all stages are empty: `wb_valid`, `front_hold`, `ex_bubble` and `squash_front` are 0.
- R2: A valid instruction in RF whose enabled source matches the nonzero destination of a writing load in EX raises `front_hold` for exactly 2 consecutive cycles, and `ex_bubble` is high in each held cycle, so EX receives an empty slot.
- R3: When exactly one instruction separates the load from its consumer, the consumer is held for exactly 1 cycle.
- R4: When two or more instructions separate the load from its consumer, there is no hold.
- R5: Three cases never cause a hold: producers that are not loads, loads whose destination is register 0, and sources whose enable bit is 0.
- R6: While `front_hold` is high the fetch inputs are not accepted and IF, IS and RF keep their contents. Every accepted instruction reaches WB exactly once and in fetch order, with `wb_tag` equal to its fetch tag.
- R7: A valid taken branch in EX raises `squash_front` for one cycle. The instruction directly after the branch still reaches WB. The next two fetched instructions never reach WB. The fetch accepted in or after the `squash_front` cycle is treated as the branch target.
- R8: A branch that is not taken raises no `squash_front`, and all following instructions reach WB.
- R9: When a hold and a taken-branch squash fall in the same cycle, only IF and IS are emptied. The delay-slot instruction stays in RF, waits out its stall and then reaches WB.
- R10: `front_hold` is never high for more than 2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | An instruction is offered to IF this cycle |
| fetch_tag | input | 8 | Identifier carried to WB |
| fetch_dest | input | 5 | Destination register |
| fetch_wr_en | input | 1 | Instruction writes its destination |
| fetch_src_a | input | 5 | First source register |
| fetch_src_a_en | input | 1 | First source is read |
| fetch_src_b | input | 5 | Second source register |
| fetch_src_b_en | input | 1 | Second source is read |
| fetch_is_load | input | 1 | Instruction is a load |
| fetch_is_branch | input | 1 | Instruction is a conditional branch |
| fetch_br_taken | input | 1 | Branch outcome, acted on in EX |
| front_hold | output | 1 | IF, IS and RF hold; the fetch input is not accepted |
| ex_bubble | output | 1 | An empty slot is sent into EX this cycle |
| squash_front | output | 1 | Taken branch in EX: empty IF and IS, redirect fetch |
| wb_valid | output | 1 | A live instruction is in WB |
| wb_tag | output | 8 | Tag of the instruction in WB |
| wb_dest | output | 5 | Destination of the instruction in WB |
| wb_wr_en | output | 1 | The instruction in WB writes its destination |

## Verification
A load interlock and a taken-branch squash can fall in the same cycle. This happens when the delay-slot instruction sits in RF and reads the result of a load that is one stage ahead of the branch, in DF. The bench sets this up with a load, then a taken branch, then a delay slot that reads the loaded register. The outcome is judged on three counts: exactly one hold cycle, exactly one squash pulse, and the writeback sequence load, branch, delay slot, target, with no trace of the two squashed fetches.

// File: rtl/ilk_pkg.sv
// Package: shared widths and the per-stage instruction descriptor.
// Assumes a register file of 2**REG_W entries in which register 0 never carries a value.
package ilk_pkg;
    localparam int REG_W       = 5;
    localparam int TAG_W       = 8;
    localparam int BACK_STAGES = 5;   // EX, DF, DS, TC, WB
    localparam int LOAD_SHADOW = 2;   // stages (EX, DF) whose load data is not yet usable
    localparam int EX_IDX      = 0;
    localparam int WB_IDX      = BACK_STAGES - 1;
    localparam int N_SRC       = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        reg_idx_t         dest;
        logic             wr_en;
        reg_idx_t         src_a;
        logic             src_a_en;
        reg_idx_t         src_b;
        logic             src_b_en;
        logic             is_load;
        logic             is_branch;
        logic             br_taken;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;
endpackage

// File: rtl/ilk_front_regs.sv
// Front stages IF, IS, RF. They advance when not held.
// A squash empties IF and IS (the slots younger than the delay slot) and leaves RF alone.
// Assumes squash can only be raised while the delay slot occupies RF.
module ilk_front_regs
    import ilk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  squash,
    input  slot_t fetch_slot,
    output slot_t if_q,
    output slot_t is_q,
    output slot_t rf_q
);
    // Stage advance, hold and squash of the three front slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q <= EMPTY_SLOT;
            is_q <= EMPTY_SLOT;
            rf_q <= EMPTY_SLOT;
        end else if (hold) begin
            if_q.valid <= if_q.valid & ~squash;
            is_q.valid <= is_q.valid & ~squash;
        end else begin
            if_q       <= fetch_slot;
            is_q       <= if_q;
            is_q.valid <= if_q.valid & ~squash;
            rf_q       <= is_q;
            rf_q.valid <= is_q.valid & ~squash;
        end
    end

    // R6: a held RF slot does not change.
    assert_front_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(rf_q));

    // R7: a squash without hold leaves no live slot in IS or RF afterwards.
    assert_squash_young_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !hold) |=> (!is_q.valid && !rf_q.valid));

    // R9: squash during hold keeps the delay slot and empties IF and IS.
    assert_keep_delay_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && hold) |=> (rf_q.valid && !if_q.valid && !is_q.valid));
endmodule

// File: rtl/ilk_back_regs.sv
// Back stages EX to WB as a shift chain.
// EX takes the RF slot, or an empty slot while the front is held.
// Squash never reaches these stages: the delay slot and everything older proceed.
module ilk_back_regs
    import ilk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  slot_t                   rf_q,
    output slot_t [BACK_STAGES-1:0] stg_q
);
    // Shift the descriptors one stage per cycle, inserting a bubble at EX on hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[EX_IDX] <= hold ? EMPTY_SLOT : rf_q;
            for (int k = 1; k < BACK_STAGES; k++) begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    // R2: a held cycle sends an empty slot into EX.
    assert_bubble_on_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !stg_q[EX_IDX].valid);
endmodule

// File: rtl/ilk_load_check.sv
// Load-use detector. The RF slot must wait while any of its enabled sources matches
// the nonzero destination of a writing load still in a stage whose data is not ready.
// Assumes results of non-load instructions are forwarded without stalling.
module ilk_load_check
    import ilk_pkg::*;
(
    input  slot_t                    rf_slot,
    input  slot_t [LOAD_SHADOW-1:0]  pend_i,
    output logic                     hold
);
    reg_idx_t               src    [N_SRC];
    logic                   src_en [N_SRC];
    logic [N_SRC*LOAD_SHADOW-1:0] hit;

    // Gather the RF sources into an indexable form.
    always_comb begin
        src[0]    = rf_slot.src_a;
        src_en[0] = rf_slot.src_a_en;
        src[1]    = rf_slot.src_b;
        src_en[1] = rf_slot.src_b_en;
    end

    for (genvar k = 0; k < LOAD_SHADOW; k++) begin : g_stage
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign hit[k*N_SRC+s] = pend_i[k].valid && pend_i[k].is_load &&
                                    pend_i[k].wr_en && (pend_i[k].dest != '0) &&
                                    src_en[s] && (src[s] == pend_i[k].dest);
        end
    end

    assign hold = rf_slot.valid && (|hit);
endmodule

// File: rtl/ilk_pipe_interlock.sv
// Top of the interlock controller. It packs the fetch inputs into a descriptor,
// tracks the front and back stages, raises the load-use hold and resolves branches in EX.
// Assumes a branch never sits in another branch's delay slot.
module ilk_pipe_interlock
    import ilk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic [REG_W-1:0] fetch_dest,
    input  logic             fetch_wr_en,
    input  logic [REG_W-1:0] fetch_src_a,
    input  logic             fetch_src_a_en,
    input  logic [REG_W-1:0] fetch_src_b,
    input  logic             fetch_src_b_en,
    input  logic             fetch_is_load,
    input  logic             fetch_is_branch,
    input  logic             fetch_br_taken,
    output logic             front_hold,
    output logic             ex_bubble,
    output logic             squash_front,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [REG_W-1:0] wb_dest,
    output logic             wb_wr_en
);
    slot_t                   fetch_slot;
    slot_t                   if_q, is_q, rf_q;
    slot_t [BACK_STAGES-1:0] back_q;
    logic                    hold;
    logic                    squash;
    logic [1:0]              hold_run;

    // Pack the fetch ports into one descriptor.
    always_comb begin
        fetch_slot           = EMPTY_SLOT;
        fetch_slot.valid     = fetch_valid;
        fetch_slot.tag       = fetch_tag;
        fetch_slot.dest      = fetch_dest;
        fetch_slot.wr_en     = fetch_wr_en;
        fetch_slot.src_a     = fetch_src_a;
        fetch_slot.src_a_en  = fetch_src_a_en;
        fetch_slot.src_b     = fetch_src_b;
        fetch_slot.src_b_en  = fetch_src_b_en;
        fetch_slot.is_load   = fetch_is_load;
        fetch_slot.is_branch = fetch_is_branch;
        fetch_slot.br_taken  = fetch_br_taken;
    end

    ilk_front_regs front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .squash     (squash),
        .fetch_slot (fetch_slot),
        .if_q       (if_q),
        .is_q       (is_q),
        .rf_q       (rf_q)
    );

    ilk_back_regs back_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .rf_q  (rf_q),
        .stg_q (back_q)
    );

    ilk_load_check ldchk_i (
        .rf_slot (rf_q),
        .pend_i  (back_q[LOAD_SHADOW-1:0]),
        .hold    (hold)
    );

    // Branch resolution in EX: a taken branch squashes the two slots after the delay slot.
    assign squash = back_q[EX_IDX].valid && back_q[EX_IDX].is_branch && back_q[EX_IDX].br_taken;

    // Drive the outputs from the stage state.
    always_comb begin
        front_hold   = hold;
        ex_bubble    = hold;
        squash_front = squash;
        wb_valid     = back_q[WB_IDX].valid;
        wb_tag       = back_q[WB_IDX].tag;
        wb_dest      = back_q[WB_IDX].dest;
        wb_wr_en     = back_q[WB_IDX].wr_en;
    end

    // Count consecutive held cycles so their length can be bounded.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_run <= '0;
        else if (hold) hold_run <= (hold_run == 2'd3) ? hold_run : hold_run + 2'd1;
        else           hold_run <= '0;
    end

    // R10: no third consecutive held cycle.
    assert_hold_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (hold_run < 2'd2));

    // R1: reset leaves the writeback stage empty one cycle later.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !wb_valid);
endmodule

// File: tb/ilk_pipe_interlock_tb.sv
`timescale 1ns/1ps
// Directed bench: each task loads a small program, runs it and checks hold, squash and writeback.
module ilk_pipe_interlock_tb_top;
    localparam int RW = 5;
    localparam int TW = 8;
    localparam int PN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          fetch_valid = 1'b0;
    logic [TW-1:0] fetch_tag = '0;
    logic [RW-1:0] fetch_dest = '0, fetch_src_a = '0, fetch_src_b = '0;
    logic          fetch_wr_en = 1'b0, fetch_src_a_en = 1'b0, fetch_src_b_en = 1'b0;
    logic          fetch_is_load = 1'b0, fetch_is_branch = 1'b0, fetch_br_taken = 1'b0;
    logic          front_hold, ex_bubble, squash_front, wb_valid, wb_wr_en;
    logic [TW-1:0] wb_tag;
    logic [RW-1:0] wb_dest;

    ilk_pipe_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
        .fetch_dest(fetch_dest), .fetch_wr_en(fetch_wr_en), .fetch_src_a(fetch_src_a),
        .fetch_src_a_en(fetch_src_a_en), .fetch_src_b(fetch_src_b), .fetch_src_b_en(fetch_src_b_en),
        .fetch_is_load(fetch_is_load), .fetch_is_branch(fetch_is_branch),
        .fetch_br_taken(fetch_br_taken), .front_hold(front_hold), .ex_bubble(ex_bubble),
        .squash_front(squash_front), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .wb_dest(wb_dest), .wb_wr_en(wb_wr_en)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic          p_v [PN];
    logic [RW-1:0] p_d [PN], p_sa [PN], p_sb [PN];
    logic          p_w [PN], p_sae [PN], p_sbe [PN], p_ld [PN], p_br [PN], p_tk [PN];
    int            br_tgt;
    int            ret_tags [16];
    int            ret_n, stall_n, bubble_n, squash_n, run_cur, run_max;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PN; i++) begin
            p_v[i] = 0; p_d[i] = '0; p_sa[i] = '0; p_sb[i] = '0; p_w[i] = 0;
            p_sae[i] = 0; p_sbe[i] = 0; p_ld[i] = 0; p_br[i] = 0; p_tk[i] = 0;
        end
        br_tgt = 0;
    endtask

    task automatic put_alu(input int i, input int d, input int a, input int b);
        p_v[i] = 1; p_d[i] = RW'(d); p_w[i] = 1; p_sa[i] = RW'(a); p_sae[i] = 1;
        p_sb[i] = RW'(b); p_sbe[i] = 1;
    endtask

    task automatic put_load(input int i, input int d, input int base);
        p_v[i] = 1; p_d[i] = RW'(d); p_w[i] = 1; p_sa[i] = RW'(base); p_sae[i] = 1; p_ld[i] = 1;
    endtask

    task automatic put_br(input int i, input bit tk, input int tgt);
        p_v[i] = 1; p_sa[i] = RW'(1); p_sae[i] = 1; p_br[i] = 1; p_tk[i] = tk; br_tgt = tgt;
    endtask

    task automatic do_reset();
        fetch_valid = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Runs the stored program; the environment redirects fetch on squash and stops on hold.
    task automatic run_prog(input int cycles);
        int  pc;
        bit  held;
        do_reset();
        pc = 0; ret_n = 0; stall_n = 0; bubble_n = 0; squash_n = 0; run_cur = 0; run_max = 0;
        repeat (cycles) begin
            if (wb_valid) begin
                if (ret_n < 16) ret_tags[ret_n] = int'(wb_tag);
                ret_n++;
            end
            stall_n  += int'(front_hold);
            bubble_n += int'(ex_bubble);
            squash_n += int'(squash_front);
            run_cur = front_hold ? run_cur + 1 : 0;
            if (run_cur > run_max) run_max = run_cur;
            if (squash_front) pc = br_tgt;
            held = front_hold;
            if (pc < PN && p_v[pc]) begin
                fetch_valid = 1; fetch_tag = TW'(pc); fetch_dest = p_d[pc]; fetch_wr_en = p_w[pc];
                fetch_src_a = p_sa[pc]; fetch_src_a_en = p_sae[pc]; fetch_src_b = p_sb[pc];
                fetch_src_b_en = p_sbe[pc]; fetch_is_load = p_ld[pc]; fetch_is_branch = p_br[pc];
                fetch_br_taken = p_tk[pc];
            end else begin
                fetch_valid = 0;
            end
            @(posedge clk);
            if (!held) pc++;
            @(negedge clk);
        end
        fetch_valid = 0;
    endtask

    task automatic expect_retire(input string req, input int n, input int e0, input int e1,
                                 input int e2, input int e3);
        int e [4];
        e = '{e0, e1, e2, e3};
        check(req, "writeback count", ret_n, n);
        for (int i = 0; i < n && i < 4; i++) check(req, "writeback tag", ret_tags[i], e[i]);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "wb_valid", int'(wb_valid), 0);
        check("R1", "front_hold", int'(front_hold), 0);
        check("R1", "ex_bubble", int'(ex_bubble), 0);
        check("R1", "squash_front", int'(squash_front), 0);
    endtask

    task automatic t_load_adjacent();
        clear_prog(); put_load(0, 5, 1); put_alu(1, 6, 5, 2);
        run_prog(30);
        check("R2", "hold cycles", stall_n, 2);
        check("R2", "bubble cycles", bubble_n, 2);
        check("R10", "longest hold run", run_max, 2);
        expect_retire("R2", 2, 0, 1, 0, 0);
    endtask

    task automatic t_load_gap2();
        clear_prog(); put_load(0, 5, 1); put_alu(1, 7, 1, 2); put_alu(2, 8, 3, 5);
        run_prog(30);
        check("R3", "hold cycles", stall_n, 1);
        expect_retire("R3", 3, 0, 1, 2, 0);
    endtask

    task automatic t_load_gap3();
        clear_prog(); put_load(0, 5, 1); put_alu(1, 7, 1, 2); put_alu(2, 8, 3, 4); put_alu(3, 9, 5, 2);
        run_prog(30);
        check("R4", "hold cycles", stall_n, 0);
        expect_retire("R4", 4, 0, 1, 2, 3);
    endtask

    task automatic t_no_interlock();
        clear_prog(); put_alu(0, 5, 1, 2); put_alu(1, 6, 5, 5);
        run_prog(25);
        check("R5", "hold after non-load producer", stall_n, 0);
        clear_prog(); put_load(0, 0, 1); put_alu(1, 6, 0, 0);
        run_prog(25);
        check("R5", "hold after load to register 0", stall_n, 0);
        clear_prog(); put_load(0, 5, 1); put_alu(1, 6, 5, 5); p_sae[1] = 0; p_sbe[1] = 0;
        run_prog(25);
        check("R5", "hold with disabled sources", stall_n, 0);
        expect_retire("R5", 2, 0, 1, 0, 0);
    endtask

    task automatic t_order_under_hold();
        clear_prog(); put_load(0, 5, 1); put_alu(1, 6, 5, 2); put_alu(2, 7, 5, 6); put_alu(3, 8, 7, 6);
        run_prog(30);
        check("R6", "hold cycles", stall_n, 2);
        expect_retire("R6", 4, 0, 1, 2, 3);
    endtask

    task automatic t_taken_branch();
        clear_prog(); put_br(0, 1, 8); put_alu(1, 4, 2, 3); put_alu(2, 5, 2, 3); put_alu(3, 6, 2, 3);
        put_alu(8, 9, 2, 3); put_alu(9, 10, 2, 3);
        run_prog(30);
        check("R7", "squash pulses", squash_n, 1);
        check("R7", "hold cycles", stall_n, 0);
        expect_retire("R7", 4, 0, 1, 8, 9);
    endtask

    task automatic t_untaken_branch();
        clear_prog(); put_br(0, 0, 8); put_alu(1, 4, 2, 3); put_alu(2, 5, 2, 3); put_alu(3, 6, 2, 3);
        run_prog(30);
        check("R8", "squash pulses", squash_n, 0);
        expect_retire("R8", 4, 0, 1, 2, 3);
    endtask

    task automatic t_hold_with_squash();
        clear_prog(); put_load(0, 5, 1); put_br(1, 1, 8); put_alu(2, 6, 5, 2);
        put_alu(3, 7, 2, 3); put_alu(4, 8, 2, 3); put_alu(8, 9, 2, 3);
        run_prog(30);
        check("R9", "hold cycles", stall_n, 1);
        check("R9", "squash pulses", squash_n, 1);
        expect_retire("R9", 4, 0, 1, 2, 8);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
                finish_run();
            end
        end
    end

    initial begin
        t_reset();
        t_load_adjacent();
        t_load_gap2();
        t_load_gap3();
        t_no_interlock();
        t_order_under_hold();
        t_taken_branch();
        t_untaken_branch();
        t_hold_with_squash();
        finish_run();
    end
endmodule